// File: doc/BRIEF.md
# Format-Driven Bus Status Tracer

This block turns a frozen snapshot of processor bus state into a stream of ASCII characters, one character per step. It is held in reset while the processor runs. When the processor is stopped and reset is released, it walks a programmable 32-byte format table from its first entry. Each format byte is one instruction:

- a literal character to print;
- a hexadecimal digit taken from one nibble of a captured 32-bit word;
- a character looked up in a 16-entry table, chosen by one bit of an 8-bit flag vector;
- the end of the trace.

Every character leaves on an 8-bit output together with a one-cycle send strobe, so a serial transmitter and a text display can take the same stream. Two pacing inputs space the characters for a slow link. A go level lets the block issue one character. A resume level must then be seen before the next go is honoured. When the format ends, the block raises a done output that stays high until the next reset.

Top module: `bus_trace_fmt`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block returns to entry 0 of the format. After that edge `out_send` and `trace_done` are low.
- R2: A format byte with bit 7 clear and a nonzero value is emitted unchanged as the character.
- R3: A format byte whose bits [7:6] are `10` selects nibble n = bits [2:0] of `cap_word`, that is `cap_word[4n+3:4n]`. The nibble is emitted as an uppercase hex digit: `0`–`9` for values 0–9 and `A`–`F` for values 10–15.
- R4: A format byte whose bits [7:6] are `11` selects flag k = bits [2:0]. It emits entry k of `chr_table` when `cap_flags[k]` is 0 and entry 8+k when it is 1. Entry i occupies `chr_table[8i+7:8i]`.
- R5: When the current format byte is 0x00 and go is taken, no character is sent. `trace_done` rises the next cycle and no further character is sent until reset.
- R6: After entry 31, the last one, has been emitted, `trace_done` rises one cycle after that entry's strobe.
- R7: Every character is presented on `out_char` in the same single cycle that `out_send` is high. `out_send` is never high while `trace_done` is high.
- R8: A character is sent in the cycle after `pace_go` is sampled high while the block is waiting for go. No second character follows until `pace_resume` has been sampled high and then `pace_go` is sampled high again.
- R9: While `pace_go` stays low, no character is sent.
- R10: Format entries are read in order from entry 0. Entry i occupies `fmt_table[8i+7:8i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; held high while the processor runs |
| pace_go | input | 1 | Pacing level that lets the next character issue |
| pace_resume | input | 1 | Pacing level that re-arms the block after a character |
| cap_word | input | 32 | Captured address and data word, the source of hex nibbles |
| cap_flags | input | 8 | Captured status flags |
| fmt_table | input | 256 | 32 format bytes, entry i at bits [8i+7:8i] |
| chr_table | input | 128 | 16 flag characters, entry i at bits [8i+7:8i] |
| out_char | output | 8 | ASCII character being sent |
| out_send | output | 1 | One-cycle send strobe |
| trace_done | output | 1 | Format exhausted; held until reset |

## Verification
A character is due exactly one clock edge after `pace_go` is sampled high in the waiting state. Done is due one edge after a terminator is taken, or one edge after the strobe of the last entry. The driver raises and lowers the pacing levels on falling edges and queues the character the requirements predict before it raises go. The monitor compares each strobe against the queue on the next falling edge, so a late, early, extra or missing character shows up as a mismatch or an unexpected strobe. The done level is checked after each full go/resume step, and that step spans three edges, enough to cover the one-edge delay in either ending.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int SEL_W  = 3;
    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        ST_ARM,
        ST_HOLD,
        ST_FINAL,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        K_END,
        K_LIT,
        K_HEX,
        K_FLAG
    } fmt_kind_e;

    typedef struct packed {
        fmt_kind_e          kind;
        logic [SEL_W-1:0]   sel;
        logic [CHAR_W-1:0]  raw;
    } fmt_op_t;

    function automatic fmt_op_t decode_op(input logic [CHAR_W-1:0] b);
        fmt_op_t op;
        op.raw = b;
        op.sel = b[SEL_W-1:0];
        if (!b[7]) begin
            op.kind = (b == '0) ? K_END : K_LIT;
        end else if (!b[6]) begin
            op.kind = K_HEX;
        end else begin
            op.kind = K_FLAG;
        end
        return op;
    endfunction

    function automatic logic [CHAR_W-1:0] hex_ascii(input logic [3:0] n);
        if (n < 4'd10) begin
            return CHAR_W'(8'h30 + {4'b0, n});
        end
        return CHAR_W'(8'h37 + {4'b0, n});
    endfunction

endpackage

// File: rtl/bt_fmt_fetch.sv
module bt_fmt_fetch
    import bt_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic [DEPTH*CHAR_W-1:0] fmt_flat,
    input  logic [PTR_W-1:0]        ptr,
    output fmt_op_t                 op
);

    logic [CHAR_W-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign entry[g] = fmt_flat[g*CHAR_W +: CHAR_W];
    end

    always_comb begin
        op = decode_op(entry[ptr]);
    end

endmodule

// File: rtl/bt_render.sv
module bt_render
    import bt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 8,
    localparam int NIB_CNT = DATA_W / 4,
    localparam int TBL_N   = 2 * FLAG_W
) (
    input  fmt_op_t                 op,
    input  logic [DATA_W-1:0]       word,
    input  logic [FLAG_W-1:0]       flags,
    input  logic [TBL_N*CHAR_W-1:0] chr_flat,
    output logic [CHAR_W-1:0]       ch
);

    logic [3:0]        nib  [NIB_CNT];
    logic [CHAR_W-1:0] ctab [TBL_N];

    for (genvar g = 0; g < NIB_CNT; g++) begin : g_nib
        assign nib[g] = word[g*4 +: 4];
    end

    for (genvar g = 0; g < TBL_N; g++) begin : g_ctab
        assign ctab[g] = chr_flat[g*CHAR_W +: CHAR_W];
    end

    logic [CHAR_W-1:0] hex_ch;
    logic [CHAR_W-1:0] flag_ch;

    always_comb begin
        hex_ch = 8'h3F;
        for (int i = 0; i < NIB_CNT; i++) begin
            if (int'(op.sel) == i) begin
                hex_ch = hex_ascii(nib[i]);
            end
        end
    end

    always_comb begin
        flag_ch = 8'h3F;
        for (int i = 0; i < FLAG_W; i++) begin
            if (int'(op.sel) == i) begin
                flag_ch = flags[i] ? ctab[FLAG_W + i] : ctab[i];
            end
        end
    end

    always_comb begin
        unique case (op.kind)
            K_HEX:   ch = hex_ch;
            K_FLAG:  ch = flag_ch;
            default: ch = op.raw;
        endcase
    end

endmodule

// File: rtl/bt_sequencer.sv
module bt_sequencer
    import bt_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              resume,
    input  logic              is_end,
    input  logic [CHAR_W-1:0] char_in,
    output logic [PTR_W-1:0]  ptr,
    output logic [CHAR_W-1:0] char_q,
    output logic              send_q,
    output logic              done
);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_ARM;
            ptr    <= '0;
            send_q <= 1'b0;
            char_q <= '0;
        end else begin
            send_q <= 1'b0;
            unique case (state)
                ST_ARM: begin
                    if (go) begin
                        if (is_end) begin
                            state <= ST_DONE;
                        end else begin
                            send_q <= 1'b1;
                            char_q <= char_in;
                            if (ptr == LAST) begin
                                state <= ST_FINAL;
                            end else begin
                                ptr   <= ptr + 1'b1;
                                state <= ST_HOLD;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (resume) begin
                        state <= ST_ARM;
                    end
                end
                ST_FINAL: state <= ST_DONE;
                default:  state <= ST_DONE;
            endcase
        end
    end

    assign done = (state == ST_DONE);

endmodule

// File: rtl/bus_trace_fmt.sv
module bus_trace_fmt
    import bt_pkg::*;
#(
    parameter int FMT_DEPTH = 32,
    parameter int DATA_W    = 32,
    parameter int FLAG_W    = 8,
    localparam int PTR_W    = $clog2(FMT_DEPTH),
    localparam int TBL_N    = 2 * FLAG_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pace_go,
    input  logic                        pace_resume,
    input  logic [DATA_W-1:0]           cap_word,
    input  logic [FLAG_W-1:0]           cap_flags,
    input  logic [FMT_DEPTH*CHAR_W-1:0] fmt_table,
    input  logic [TBL_N*CHAR_W-1:0]     chr_table,
    output logic [CHAR_W-1:0]           out_char,
    output logic                        out_send,
    output logic                        trace_done
);

    logic [PTR_W-1:0]  ptr;
    fmt_op_t           op;
    logic [CHAR_W-1:0] rendered;

    bt_fmt_fetch #(.DEPTH(FMT_DEPTH)) fetch_i (
        .fmt_flat (fmt_table),
        .ptr      (ptr),
        .op       (op)
    );

    bt_render #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) render_i (
        .op       (op),
        .word     (cap_word),
        .flags    (cap_flags),
        .chr_flat (chr_table),
        .ch       (rendered)
    );

    bt_sequencer #(.DEPTH(FMT_DEPTH)) seq_i (
        .clk     (clk),
        .rst     (rst),
        .go      (pace_go),
        .resume  (pace_resume),
        .is_end  (op.kind == K_END),
        .char_in (rendered),
        .ptr     (ptr),
        .char_q  (out_char),
        .send_q  (out_send),
        .done    (trace_done)
    );

endmodule

// File: rtl/bt_trace_chk.sv
module bt_trace_chk (
    input logic clk,
    input logic rst,
    input logic pace_go,
    input logic out_send,
    input logic trace_done
);

    // R7: a strobe and done never coincide
    a_r7_send_excl_done: assert property (@(posedge clk) disable iff (rst)
        out_send |-> !trace_done);

    // R7: strobe lasts one cycle
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
        out_send |=> !out_send);

    // R5: done holds until reset
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
        trace_done |=> trace_done);

    // R5: nothing is sent once done
    a_r5_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        trace_done |=> !out_send);

    // R1: reset leaves the outputs idle
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!trace_done && !out_send));

    // R8: every strobe follows a sampled go
    a_r8_go_before_send: assert property (@(posedge clk) disable iff (rst)
        out_send |-> $past(pace_go));

endmodule

bind bus_trace_fmt bt_trace_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .pace_go    (pace_go),
    .out_send   (out_send),
    .trace_done (trace_done)
);

// File: tb/bus_trace_fmt_tb_top.sv
module bus_trace_fmt_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pace_go = 1'b0;
    logic         pace_resume = 1'b0;
    logic [31:0]  cap_word = '0;
    logic [7:0]   cap_flags = '0;
    logic [255:0] fmt_table = '0;
    logic [127:0] chr_table = '0;
    logic [7:0]   out_char;
    logic         out_send;
    logic         trace_done;

    always #5 clk = ~clk;

    bus_trace_fmt dut_i (
        .clk         (clk),
        .rst         (rst),
        .pace_go     (pace_go),
        .pace_resume (pace_resume),
        .cap_word    (cap_word),
        .cap_flags   (cap_flags),
        .fmt_table   (fmt_table),
        .chr_table   (chr_table),
        .out_char    (out_char),
        .out_send    (out_send),
        .trace_done  (trace_done)
    );

    int         vectors = 0;
    int         errors  = 0;
    int         sends   = 0;
    int         bpos    = 0;
    bit         bdone   = 0;
    bit         finished = 0;
    logic [7:0] exp_q [$];

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] b);
        logic [3:0] n;
        int         idx;
        if (!b[7]) return b;                               // R2
        if (!b[6]) begin                                   // R3
            n = cap_word[int'(b[2:0])*4 +: 4];
            return (n < 4'd10) ? 8'(8'h30 + n) : 8'(8'h41 + n - 4'd10);
        end
        idx = cap_flags[b[2:0]] ? 8 + int'(b[2:0]) : int'(b[2:0]);  // R4
        return chr_table[idx*8 +: 8];
    endfunction

    task automatic set_fmt(input int i, input logic [7:0] b);
        fmt_table[i*8 +: 8] = b;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pace_go = 1'b0;
        pace_resume = 1'b0;
        repeat (2) @(negedge clk);
        check(!out_send && !trace_done, "R1 idle in reset",
              {out_send, trace_done}, 0);
        rst = 1'b0;
        bpos = 0;
        bdone = 0;
        exp_q.delete();
    endtask

    // driver: predict, then pulse go and resume
    task automatic advance();
        logic [7:0] b;
        if (!bdone) begin
            b = fmt_table[bpos*8 +: 8];
            if (b == 8'h00) begin
                bdone = 1;                                  // R5
            end else begin
                exp_q.push_back(model(b));                  // R10 order
                bpos++;
                if (bpos == 32) bdone = 1;                  // R6
            end
        end
        @(negedge clk) pace_go = 1'b1;
        @(negedge clk) begin pace_go = 1'b0; pace_resume = 1'b1; end
        @(negedge clk) pace_resume = 1'b0;
        check(trace_done == bdone, "R5 R6 done level", trace_done, bdone);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_send) begin
            sends++;
            check(!trace_done, "R7 send while done", trace_done, 0);
            if (exp_q.size() == 0) begin
                check(0, "R8 unexpected send", out_char, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(out_char == e, "R2/R3/R4 char", out_char, e);
            end
        end
    end

    task automatic load_scenario_a();
        logic [7:0] f [26];
        f = '{8'h3E, 8'hC0, 8'hC1, 8'h20, 8'hC6, 8'hC7, 8'h20, 8'h41, 8'h3D,
              8'h87, 8'h86, 8'h85, 8'h84, 8'h83, 8'h82, 8'h81, 8'h80,
              8'h20, 8'h44, 8'h3D, 8'hC5, 8'hC4, 8'hC3, 8'hC2, 8'h0D, 8'h00};
        for (int i = 0; i < 32; i++) set_fmt(i, (i < 26) ? f[i] : 8'h5A);
    endtask

    task automatic run_to_done(input string tag);
        int guard = 0;
        while (!bdone && guard < 40) begin
            advance();
            guard++;
        end
        repeat (3) advance();
        check(trace_done == 1'b1, tag, trace_done, 1);
        check(exp_q.size() == 0, "R7 all chars seen", exp_q.size(), 0);
    endtask

    initial begin
        int s0;
        for (int i = 0; i < 16; i++) chr_table[i*8 +: 8] = 8'(8'h61 + i);
        do_reset();
        repeat (3) @(negedge clk);
        check(!out_send && !trace_done, "R1 idle after release",
              {out_send, trace_done}, 0);

        // R9: no go, no output
        s0 = sends;
        repeat (10) @(negedge clk);
        check(sends == s0, "R9 silent without go", sends, s0);

        // scenario A: literals, hex, flags, terminator (R2 R3 R4 R5)
        cap_word  = 32'h9A0F_3C6B;
        cap_flags = 8'b1010_0110;
        load_scenario_a();
        run_to_done("R5 done after terminator");

        // same format, complementary flags and another word (R3 R4)
        do_reset();
        cap_word  = 32'hE5D4_2C71;
        cap_flags = 8'b0101_1001;
        run_to_done("R5 done second pattern");

        // R8: go held high without resume yields one char only
        do_reset();
        exp_q.push_back(model(fmt_table[7:0]));
        bpos = 1;
        s0 = sends;
        @(negedge clk) pace_go = 1'b1;
        repeat (5) @(negedge clk);
        pace_go = 1'b0;
        check(sends == s0 + 1, "R8 one char per go", sends, s0 + 1);
        @(negedge clk) pace_resume = 1'b1;
        @(negedge clk) pace_resume = 1'b0;
        advance();
        check(sends == s0 + 2, "R8 next char after resume", sends, s0 + 2);

        // R11 style restart: reset mid-trace goes back to entry 0 (R1 R10)
        advance();
        advance();
        do_reset();
        s0 = sends;
        advance();
        check(sends == s0 + 1, "R1 restart from entry 0", sends, s0 + 1);

        // R6: full table without terminator
        do_reset();
        for (int i = 0; i < 32; i++)
            set_fmt(i, (i % 2 == 0) ? 8'(8'h30 + i) : 8'(8'h80 | (i % 8)));
        s0 = sends;
        run_to_done("R6 done after last entry");
        check(sends == s0 + 32, "R6 thirty-two chars", sends, s0 + 32);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            vectors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule